// File: doc/BRIEF.md
# Pulse-Driven Bistable Receiver with Activity Watchdog

This block is the receiving end of a channel that carries a logic level as short event pulses instead of as a level. A pulse on the set line means the sender's input went (or still is) high; a pulse on the clear line means it went (or still is) low. The block holds the most recent level in a bistable register, so the output stays put between pulses. The sender also repeats the current level from time to time, so a quiet line normally still sees a pulse every so often.

A watchdog counts clock cycles since the last pulse of either kind. When that count reaches a parameterised limit (default 500 cycles, 5 µs at 100 MHz), the block treats the sender as unpowered or broken. It then drives the output to the safe level, high, and raises a timeout flag. The first pulse after that clears the flag and loads the output straight from that pulse. Because the sender's periodic repeat counts as a pulse, the output is correct again within one repeat interval after the sender comes back. A reset leaves the output high and the flag raised until a pulse arrives.

Top module: `pulse_decoder_wd`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `dout` is 1 and `timeout` is 1.
- R2: A cycle with `set_pulse`=1 and `clr_pulse`=0 makes `dout` 1 after the next rising edge.
- R3: A cycle with `clr_pulse`=1 and `set_pulse`=0 makes `dout` 0 after the next rising edge.
- R4: A cycle with neither pulse, while not timed out and not reaching the limit, leaves `dout` and `timeout` unchanged.
- R5: A cycle with both pulses high leaves `dout` unchanged. It still counts as activity, so `timeout` is 0 after the edge and the idle count restarts.
- R6: After LIMIT consecutive pulse-free cycles, `timeout` and `dout` are both 1 after the edge that samples the LIMIT-th such cycle. After LIMIT-1 such cycles `timeout` is still 0.
- R7: While timed out with no pulses, `timeout` stays 1 and `dout` stays 1.
- R8: The first pulse after a timeout clears `timeout` at the next edge and sets `dout` from that pulse in the same edge (0 for a clear pulse, 1 for a set pulse, unchanged-high for both).
- R9: Pulses that arrive at most LIMIT-1 cycles apart, such as periodic repeats of an unchanged level, keep `timeout` at 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 1 | One-cycle event: sender level is high |
| clr_pulse | input | 1 | One-cycle event: sender level is low |
| dout | output | 1 | Recovered level, forced high on timeout |
| timeout | output | 1 | High while the watchdog has expired |

## Verification
Every result of a pulse is due one rising edge after the cycle in which the pulse is presented. The timeout is due at the edge that samples the LIMIT-th consecutive idle cycle, and the release is due one edge after the next pulse. The bench drives inputs on the falling edge and samples one time unit after the following rising edge, against a cycle model kept in the bench. It checks every cycle, including the cycle just before the limit is reached and the cycle that reaches it.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_BOTH = 2'b11
    } act_e;

    typedef struct packed {
        logic active;
        act_e kind;
    } evt_t;

    localparam logic SAFE_LEVEL = 1'b1;

    function automatic evt_t classify(input logic s, input logic c);
        evt_t e;
        e.kind   = act_e'({c, s});
        e.active = s | c;
        return e;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pdec_classify.sv
module pdec_classify
    import pdec_pkg::*;
(
    input  logic set_pulse,
    input  logic clr_pulse,
    output evt_t evt
);
    always_comb begin
        evt = classify(set_pulse, clr_pulse);
    end
endmodule

// File: rtl/pdec_watchdog.sv
module pdec_watchdog
    import pdec_pkg::*;
#(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    output logic trip,
    output logic expired
);
    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] idle_cnt;

    // the edge that samples the LIMIT-th quiet cycle trips the watchdog
    always_comb begin
        trip = !evt.active && !expired && (idle_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            expired  <= 1'b1;
        end else if (evt.active) begin
            idle_cnt <= '0;
            expired  <= 1'b0;
        end else if (trip) begin
            expired  <= 1'b1;
        end else if (!expired) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pdec_level.sv
module pdec_level
    import pdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  logic trip,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= SAFE_LEVEL;
        end else if (trip) begin
            level <= SAFE_LEVEL;
        end else begin
            unique case (evt.kind)
                ACT_SET:  level <= 1'b1;
                ACT_CLR:  level <= 1'b0;
                default:  level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pulse_decoder_wd.sv
module pulse_decoder_wd
    import pdec_pkg::*;
#(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic dout,
    output logic timeout
);
    evt_t evt;
    logic trip;
    logic expired;
    logic level;

    pdec_classify u_cls (
        .set_pulse (set_pulse),
        .clr_pulse (clr_pulse),
        .evt       (evt)
    );

    pdec_watchdog #(.LIMIT(LIMIT)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .trip    (trip),
        .expired (expired)
    );

    pdec_level u_lvl (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .trip  (trip),
        .level (level)
    );

    assign dout    = level;
    assign timeout = expired;
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
    parameter int unsigned LIMIT = 500
) (
    input logic clk,
    input logic rst,
    input logic set_pulse,
    input logic clr_pulse,
    input logic dout,
    input logic timeout
);
    localparam int unsigned QW = $clog2(LIMIT + 1) + 1;
    localparam logic [QW-1:0] QLIM = QW'(LIMIT);

    logic [QW-1:0] quiet;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet <= '0;
            seen  <= 1'b0;
        end else if (set_pulse || clr_pulse) begin
            quiet <= '0;
            seen  <= 1'b1;
        end else if (quiet != QLIM) begin
            quiet <= quiet + 1'b1;
        end
    end

    // R1
    p_reset_state_r1: assert property (@(posedge clk) rst |=> (dout && timeout));

    p_set_high_r2: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && !clr_pulse) |=> dout);

    p_clr_low_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !set_pulse) |=> !dout);

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!set_pulse && !clr_pulse && !timeout) |=> (timeout || $stable(dout)));

    p_both_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && clr_pulse) |=> ($stable(dout) && !timeout));

    p_forced_high_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |-> dout);

    p_limit_reached_r6: assert property (@(posedge clk) disable iff (rst)
        (quiet == QLIM) |-> timeout);

    p_no_early_trip_r9: assert property (@(posedge clk) disable iff (rst)
        (seen && quiet < QLIM) |-> !timeout);

    p_stay_expired_r7: assert property (@(posedge clk) disable iff (rst)
        (timeout && !set_pulse && !clr_pulse) |=> timeout);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (timeout && (set_pulse || clr_pulse)) |=> !timeout);
endmodule

bind pulse_decoder_wd pdec_checker #(.LIMIT(LIMIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_pulse),
    .clr_pulse (clr_pulse),
    .dout      (dout),
    .timeout   (timeout)
);

// File: tb/pulse_decoder_wd_test.sv
module pulse_decoder_wd_test;
    localparam int unsigned LIMIT  = 24;
    localparam time         PERIOD = 10;
    localparam int          WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_pulse = 1'b0;
    logic clr_pulse = 1'b0;
    logic dout;
    logic timeout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_q  = 1'b1;
    bit m_to = 1'b1;
    int m_cnt = 0;

    always #(PERIOD / 2) clk = ~clk;

    pulse_decoder_wd #(.LIMIT(LIMIT)) uut (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (set_pulse),
        .clr_pulse (clr_pulse),
        .dout      (dout),
        .timeout   (timeout)
    );

    task automatic check(input string what, input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // model of one clock cycle, derived from the requirements
    function automatic string model_step(input bit s, input bit c);
        string tag;
        if (s || c) begin
            tag = m_to ? "R8" : ((s && c) ? "R5" : (s ? "R2" : "R3"));
            m_to  = 1'b0;
            m_cnt = 0;
            if (s && !c) m_q = 1'b1;
            else if (c && !s) m_q = 1'b0;
        end else if (!m_to) begin
            if (m_cnt == int'(LIMIT) - 1) begin
                m_to = 1'b1;
                m_q  = 1'b1;
                tag  = "R6";
            end else begin
                m_cnt++;
                tag = "R4";
            end
        end else begin
            tag = "R7";
        end
        return tag;
    endfunction

    task automatic step(input bit s, input bit c, input string force_tag);
        string tag;
        @(negedge clk);
        set_pulse = s;
        clr_pulse = c;
        tag = model_step(s, c);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        #1;
        check("dout", dout, m_q, tag);
        check("timeout", timeout, m_to, tag);
    endtask

    task automatic idle(input int n, input string force_tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, force_tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd20517);

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("dout", dout, 1'b1, "R1");
        check("timeout", timeout, 1'b1, "R1");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("dout", dout, 1'b1, "R1");
        check("timeout", timeout, 1'b1, "R1");

        // idle while timed out after reset, then first pulse releases
        idle(3, "R7");
        step(1'b0, 1'b1, "R8");
        // limit boundary: LIMIT-1 idle stays, LIMIT-th trips
        idle(int'(LIMIT) - 1, "R4");
        step(1'b0, 0, "R6");
        idle(5, "R7");
        step(1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, "R5");
        idle(4, "R4");
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, "R5");
        // both pulses while expired: level stays high, flag drops
        idle(int'(LIMIT), "");
        step(1'b1, 1'b1, "R8");

        // R9: repeats at LIMIT-1 spacing never trip
        for (int k = 0; k < 6; k++) begin
            step(k[0], !k[0], "R9");
            idle(int'(LIMIT) - 2, "R9");
        end

        // constrained random traffic with periodic long silences
        for (int n = 0; n < 4000; n++) begin
            if (n % 300 == 299) begin
                idle(int'(LIMIT) + int'($urandom_range(0, 6)), "");
            end else begin
                r = $urandom_range(0, 7);
                case (r)
                    0: step(1'b1, 1'b0, "");
                    1: step(1'b0, 1'b1, "");
                    2: step(1'b1, 1'b1, "");
                    default: step(1'b0, 1'b0, "");
                endcase
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule